// File: doc/BRIEF.md
# Zero-Crossing Phase Meter

This block measures how far apart in phase two square waves are. One wave comes from a zero-crossing comparator on a resonant inverter's output voltage. The other comes from a comparator on the voltage across the series resonant capacitor. Both raw comparator outputs first pass through two-flop synchronisers. The synchronised bits are then exclusive-ORed. The XOR bit feeds a first-order digital low-pass filter that updates on every clock. Once the loop has settled, the filtered value equals the XOR duty, which is the phase difference divided by pi.

The result is an unsigned fixed-point fraction in which 1.0 stands for an XOR that is high all the time. When the inverter current is in phase with its voltage, the two voltages are in quadrature and the block reads 0.5. A downstream period controller wants to see exactly that value. The controller owns a sample strobe. The filter runs freely, and the output register loads the filter value only on a clock edge where the strobe is high. Between strobes it holds the last loaded value, so the controller reads a value that does not change.

Top module: `zc_phase_meter`

## Requirements
- R1: While `rst_n` is low, `phase_out` reads 0 and the filter state is cleared. The first sample after reset, taken with equal inputs, reads exactly 0.
- R2: `phase_out` is unsigned with `FRAC_W` fractional bits and one integer bit, so 1.0 is encoded as 2^FRAC_W (65536 by default). It never exceeds that code.
- R3: `phase_out` changes only on a rising clock edge where `sample_strobe` is high. On edges where the strobe is low it keeps its value, whatever the inputs do.
- R4: Each input passes through two synchroniser flops before the XOR. With the strobe held high and the filter cleared, an input difference that starts just after edge 0 leaves `phase_out` at 0 through edge 3. It first turns nonzero on edge 4.
- R5: On each clock the filter applies x <- x + (u - x)·2^-SHIFT, where u is the synchronised XOR bit. The value is kept at SHIFT extra fractional bits, and the output is truncated from it. From a cleared state with u held at 1, the first two held outputs are 2^(FRAC_W-SHIFT) and 2·2^(FRAC_W-SHIFT) - 2^(FRAC_W-2·SHIFT), which are 1024 and 2032 by default.
- R6: With u held at 1 from a cleared state for N updates, the output is within 0.2% of full scale of (1 - (1 - 2^-SHIFT)^N)·2^FRAC_W.
- R7: Inputs held in phase settle to exactly 0. Inputs held in antiphase settle to exactly 2^FRAC_W, and the output then stays there.
- R8: With periodic inputs, the settled output tracks the XOR duty. Quadrature (duty 1/2) reads 0.5 and duty 1/4 reads 0.25, each within 3% of full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_volt | input | 1 | Zero-crossing square wave of the inverter output voltage, asynchronous |
| zc_cap | input | 1 | Zero-crossing square wave of the resonant capacitor voltage, asynchronous |
| sample_strobe | input | 1 | Loads the current filter value into `phase_out` |
| phase_out | output | FRAC_W+1 | Held phase reading; 2^FRAC_W means 1.0 |

## Verification
The endpoints of the output range are the hardest part to reach from the ports. The filter only reaches the exact codes 0 and 2^FRAC_W after a long tail: in the last stretch the truncated update moves the state by one least significant bit per clock. The stimulus therefore holds antiphase and then in-phase inputs for thousands of cycles before sampling, and then strobes on every cycle to confirm the code stays put. The synchroniser latency is pinned down separately. Starting from a freshly cleared filter, the strobe is held high and one input flips, and every held value is scored edge by edge.

// File: rtl/zc_phase_meter.sv
`timescale 1ns/1ps
module zc_phase_meter #(
  parameter int FRAC_W = 16,
  parameter int SHIFT  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            zc_volt,
  input  logic            zc_cap,
  input  logic            sample_strobe,
  output logic [FRAC_W:0] phase_out
);
  localparam int ACC_W = FRAC_W + SHIFT + 1;

  logic [1:0]       volt_s, cap_s;
  logic             xor_s;
  logic [ACC_W-1:0] acc, acc_nxt, step;

  assign xor_s   = volt_s[1] ^ cap_s[1];
  assign step    = {{SHIFT{1'b0}}, 1'b1, {FRAC_W{1'b0}}};
  assign acc_nxt = acc - (acc >> SHIFT) + (xor_s ? step : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      volt_s    <= '0;
      cap_s     <= '0;
      acc       <= '0;
      phase_out <= '0;
    end else begin
      volt_s <= {volt_s[0], zc_volt};
      cap_s  <= {cap_s[0], zc_cap};
      acc    <= acc_nxt;
      if (sample_strobe) phase_out <= acc[ACC_W-1:SHIFT];
    end
  end
endmodule

// File: rtl/zc_phase_meter_chk.sv
`timescale 1ns/1ps
module zc_phase_meter_chk #(
  parameter int FRAC_W = 16,
  parameter int SHIFT  = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      zc_volt,
  input logic                      zc_cap,
  input logic                      sample_strobe,
  input logic [FRAC_W:0]           phase_out,
  input logic                      xor_s,
  input logic [FRAC_W+SHIFT:0]     acc
);
  localparam logic [FRAC_W:0] ONE = {1'b1, {FRAC_W{1'b0}}};

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  assert_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_out <= ONE);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_strobe |=> $stable(phase_out));

  assert_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (xor_s == ($past(zc_volt, 2) ^ $past(zc_cap, 2))));

  assert_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xor_s |=> acc >= $past(acc));

  assert_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !xor_s |=> acc <= $past(acc));
endmodule

bind zc_phase_meter zc_phase_meter_chk #(.FRAC_W(FRAC_W), .SHIFT(SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .zc_volt(zc_volt), .zc_cap(zc_cap),
  .sample_strobe(sample_strobe), .phase_out(phase_out),
  .xor_s(xor_s), .acc(acc)
);

// File: tb/zc_phase_meter_tb.sv
`timescale 1ns/1ps
module zc_phase_meter_tb;
  localparam int F = 16;
  localparam int S = 6;
  localparam int ONE = 1 << F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zc_volt = 1'b0, zc_cap = 1'b0, sample_strobe = 1'b0;
  logic [F:0] phase_out;

  always #10 clk = ~clk;

  zc_phase_meter #(.FRAC_W(F), .SHIFT(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .zc_volt(zc_volt), .zc_cap(zc_cap),
    .sample_strobe(sample_strobe), .phase_out(phase_out)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int    exp_q[$];
  int    tol_q[$];
  string tag_q[$];

  task automatic compare(string tag, int act, int exp, int tol);
    int d;
    d = act - exp;
    if (d < 0) d = -d;
    total++;
    if (d > tol) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d tol=%0d", tag, act, exp, tol);
    end
  endtask

  // monitor: pops one expected item per captured strobe
  logic took_sample = 1'b0;
  always @(posedge clk) took_sample <= sample_strobe && rst_n;
  always @(negedge clk) begin
    if (took_sample && exp_q.size() > 0) begin
      compare(tag_q.pop_front(), int'(phase_out), exp_q.pop_front(), tol_q.pop_front());
    end
  end

  // periodic wave generator
  bit gen_on = 0;
  int gen_p = 4, gen_lag = 0, gph = 0;
  always begin
    @(posedge clk); #2;
    if (gen_on) begin
      gph = (gph + 1) % gen_p;
      zc_volt = (gph < gen_p / 2);
      zc_cap  = (((gph - gen_lag + gen_p) % gen_p) < gen_p / 2);
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic expect_item(string tag, int exp, int tol);
    exp_q.push_back(exp);
    tol_q.push_back(tol);
    tag_q.push_back(tag);
  endtask

  task automatic sample(string tag, int exp, int tol);
    expect_item(tag, exp, tol);
    sample_strobe = 1'b1;
    tick(1);
    sample_strobe = 1'b0;
    tick(1);
  endtask

  task automatic do_reset();
    gen_on = 0;
    zc_volt = 1'b0;
    zc_cap = 1'b0;
    rst_n = 1'b0;
    tick(3);
    @(negedge clk);
    compare("R1 reset value", int'(phase_out), 0, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic run_gen(int p, int lag, int cycles);
    gen_p = p;
    gen_lag = lag;
    gph = 0;
    gen_on = 1;
    tick(cycles);
  endtask

  initial begin
    real r;
    int e;
    tick(1);
    do_reset();
    sample("R1 first sample after reset", 0, 0);

    // R4/R5: latency through synchronisers and first two updates
    zc_cap = 1'b1;
    sample_strobe = 1'b1;
    expect_item("R4 edge1", 0, 0);
    expect_item("R4 edge2", 0, 0);
    expect_item("R4 edge3", 0, 0);
    expect_item("R5 first update", 1 << (F - S), 0);
    expect_item("R5 second update", 2 * (1 << (F - S)) - (1 << (F - 2 * S)), 0);
    tick(5);
    sample_strobe = 1'b0;
    tick(2);

    // R6: step response after N updates
    do_reset();
    zc_volt = 1'b1;
    tick(66);
    r = 1.0;
    for (int i = 0; i < 64; i++) r = r * (1.0 - 1.0 / real'(1 << S));
    e = int'((1.0 - r) * real'(ONE));
    sample("R6 step after 64 updates", e, ONE / 500);

    // R7: antiphase settles to exactly full scale and stays
    run_gen(4, 2, 3000);
    sample("R7 antiphase full scale", ONE, 0);
    sample_strobe = 1'b1;
    for (int i = 0; i < 20; i++) expect_item("R2 held at full scale", ONE, 0);
    tick(20);
    sample_strobe = 1'b0;
    tick(2);

    // R7: in phase settles to exactly zero
    run_gen(4, 0, 3000);
    sample("R7 in phase zero", 0, 0);

    // R3: output holds while strobe is low
    run_gen(4, 2, 300);
    @(negedge clk);
    compare("R3 hold while strobe low", int'(phase_out), 0, 0);
    @(posedge clk); #2;
    r = 1.0;
    for (int i = 0; i < 290; i++) r = r * (1.0 - 1.0 / real'(1 << S));
    sample("R3 load on strobe", int'((1.0 - r) * real'(ONE)), ONE / 100);

    // R8: duty proportionality
    run_gen(4, 1, 3000);
    sample("R8 quadrature half", ONE / 2, ONE * 3 / 100);
    run_gen(8, 1, 3000);
    sample("R8 quarter duty", ONE / 4, ONE * 3 / 100);
    run_gen(8, 3, 3000);
    sample("R8 three quarter duty", ONE * 3 / 4, ONE * 3 / 100);

    // R1: reset in mid run clears state
    run_gen(4, 1, 500);
    do_reset();
    sample("R1 cleared after mid-run reset", 0, 0);

    tick(3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule